// File: doc/BRIEF.md
# Feed-Forward PWM Cycle Timer

This block sets the timing of a forward-converter primary switch. It runs a free-running cycle counter, and each cycle is split into a high phase of seven tenths and a low phase. At the start of each cycle it computes the permitted switch on-time from four quantised inputs: an input-voltage code, an opto-feedback code, a reference-current code and a soft-start level. The on-time is inversely proportional to the input-voltage code, so on-time times voltage stays constant. The reference code sets the highest switching frequency, and the on-time scales with the same code, so the duty cycle does not depend on frequency.

The opto code chooses one of three operating regions. In the full region, the frequency and the on-time reference are both at maximum. In the trim region, the on-time shrinks with the opto code down to a floor. In the stretch region, the on-time stays at the floor and the cycle is made longer instead, down to about a fifth of the top frequency. A soft-start level scales the on-time from zero, and reaches full scale at about 85 % of its code range. The values are latched at each cycle start. The downstream gate sequencer receives a one-cycle start strobe, the phase clock and the latched on-time count.

Top module: `ffpwm_gen`

## Requirements
- R1: While `rst` is high, at the next clock edge `cyc_start`, `cyc_clk`, `on_time` and `region` all read 0.
- R2: Define ie = max(iref_sel,1). In the full and trim regions the cycle length, measured in clocks between consecutive `cyc_start` pulses, is Pm = floor(PERIOD_K/ie).
- R3: The high phase of each cycle is H = floor(7·P/10) clocks, where P is that cycle's length. `cyc_clk` is high for the first H clocks of the cycle and low for the rest. `on_time` never exceeds H.
- R4: Define v = max(vin_code,1). The feed-forward on-time is Tf = min(floor(7·Pm/10), (Pm·VD_K·floor(65536/v)) >> 16).
- R5: When opto_code ≥ 2^DMAX_SH, `region` reads 0 (full) and the on-time reference is Tf.
- R6: When 4·ie ≤ opto_code < 2^DMAX_SH, `region` reads 1 (trim). The on-time reference is max(TON_MIN, (Tf·opto_code) >> DMAX_SH) and the cycle length is Pm.
- R7: When opto_code < 4·ie, `region` reads 2 (stretch). The on-time reference is TON_MIN and the cycle length is Pm + (4·ie − opto_code)·floor(PERIOD_K/ie²).
- R8: The soft-start gain is g = min(ss_level·SS_NUM, 65536). The output is `on_time` = min((ref·g) >> 16, H), where ref is the on-time reference from R5–R7.
- R9: `on_time` and `region` change only in a cycle in which `cyc_start` is high. An input change made during a cycle takes effect at the next cycle start.
- R10: `cyc_start` is high for exactly the first clock of each cycle, and `cyc_clk` is high in that clock. `cyc_clk` rises only together with `cyc_start`.
- R11: No cycle is longer than 5·PERIOD_K/ie clocks, whatever the opto code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| vin_code | input | VIN_W | quantised input-voltage code |
| opto_code | input | OPTO_W | quantised opto-feedback code |
| iref_sel | input | IREF_W | reference-current code |
| ss_level | input | SS_W | soft-start level |
| cyc_start | output | 1 | one-clock strobe at cycle start |
| cyc_clk | output | 1 | phase clock, high during the first 70 % of the cycle |
| on_time | output | 16 | latched on-time count for the current cycle |
| region | output | 2 | latched regulation region: 0 full, 1 trim, 2 stretch |

## Verification
The latched plan holds three quantities, and a wrong value in any of them shows at the ports within one cycle of the start that loaded it. A wrong period value moves the next `cyc_start`. A wrong high-phase value moves the fall of `cyc_clk`. A wrong on-time or region reads out directly at the start strobe. A fault in the cycle counter or the load control shows as a `cyc_start` spacing that differs from the expected length, or as an on-time that changes in mid-cycle.

// File: rtl/ffpwm_pkg.sv
package ffpwm_pkg;

    localparam int TW = 16;

    typedef logic [TW-1:0] tick_t;

    typedef enum logic [1:0] {
        REG_FULL    = 2'd0,
        REG_TRIM    = 2'd1,
        REG_STRETCH = 2'd2
    } region_e;

    typedef struct packed {
        tick_t   period;
        tick_t   high;
        tick_t   ontime;
        region_e region;
    } cycle_plan_t;

    // high phase is seven tenths of the cycle, rounded down
    function automatic tick_t high_phase(input tick_t p);
        logic [TW+3:0] w;
        w = (TW+4)'(p) * (TW+4)'(7);
        return tick_t'(w / (TW+4)'(10));
    endfunction

endpackage

// File: rtl/ffpwm_ref_lut.sv
module ffpwm_ref_lut
    import ffpwm_pkg::*;
#(
    parameter int IREF_W   = 4,
    parameter int PERIOD_K = 700,
    localparam int TH_W    = IREF_W + 2,
    localparam int N_REF   = 1 << IREF_W
) (
    input  logic [IREF_W-1:0] iref_sel,
    output tick_t             pmax,
    output tick_t             stretch_step,
    output logic [TH_W-1:0]   th_low
);

    tick_t           pmax_tab [N_REF];
    tick_t           step_tab [N_REF];
    logic [TH_W-1:0] th_tab   [N_REF];

    for (genvar g = 0; g < N_REF; g++) begin : g_ref
        localparam int IE = (g == 0) ? 1 : g;
        assign pmax_tab[g] = tick_t'(PERIOD_K / IE);
        assign step_tab[g] = tick_t'(PERIOD_K / (IE * IE));
        assign th_tab[g]   = TH_W'(4 * IE);
    end

    assign pmax         = pmax_tab[iref_sel];
    assign stretch_step = step_tab[iref_sel];
    assign th_low       = th_tab[iref_sel];

endmodule

// File: rtl/ffpwm_ontime_calc.sv
module ffpwm_ontime_calc
    import ffpwm_pkg::*;
#(
    parameter int IREF_W  = 4,
    parameter int VIN_W   = 8,
    parameter int OPTO_W  = 8,
    parameter int SS_W    = 8,
    parameter int VD_K    = 64,
    parameter int DMAX_SH = 7,
    parameter int TON_MIN = 6,
    parameter int SS_NUM  = 301,
    localparam int TH_W   = IREF_W + 2,
    localparam int CW     = (OPTO_W > TH_W) ? OPTO_W : TH_W,
    localparam int N_VIN  = 1 << VIN_W,
    localparam int OPTO_FULL = 1 << DMAX_SH,
    localparam int TRW    = TW + OPTO_W,
    localparam int SSW    = TW + 17
) (
    input  logic [VIN_W-1:0]  vin_code,
    input  logic [OPTO_W-1:0] opto_code,
    input  logic [SS_W-1:0]   ss_level,
    input  tick_t             pmax,
    input  tick_t             stretch_step,
    input  logic [TH_W-1:0]   th_low,
    output cycle_plan_t       plan
);

    // reciprocal table: floor(65536 / max(v,1))
    logic [16:0] recip_tab [N_VIN];
    for (genvar g = 0; g < N_VIN; g++) begin : g_rcp
        localparam int VE = (g == 0) ? 1 : g;
        assign recip_tab[g] = 17'(65536 / VE);
    end

    logic [16:0] rcp;
    logic [47:0] ff_wide;
    logic [47:0] ff_sh;
    tick_t       hmax;
    tick_t       t_full;

    assign rcp     = recip_tab[vin_code];
    assign ff_wide = 48'(pmax) * 48'(VD_K) * 48'(rcp);
    assign ff_sh   = ff_wide >> 16;
    assign hmax    = high_phase(pmax);
    assign t_full  = (ff_sh > 48'(hmax)) ? hmax : ff_sh[TW-1:0];

    // trim region: on-time proportional to the opto code
    logic [TRW-1:0] trim_w;
    logic [TRW-1:0] trim_sh;
    tick_t          t_trim;

    assign trim_w  = TRW'(t_full) * TRW'(opto_code);
    assign trim_sh = trim_w >> DMAX_SH;
    assign t_trim  = (trim_sh < TRW'(TON_MIN)) ? tick_t'(TON_MIN) : trim_sh[TW-1:0];

    // stretch region: longer cycle as the opto code falls
    logic    in_full;
    logic    in_low;
    logic [CW-1:0] deficit;
    tick_t   p_add;
    tick_t   p_str;

    assign in_full = ({1'b0, opto_code} >= (OPTO_W+1)'(OPTO_FULL));
    assign in_low  = (CW'(opto_code) < CW'(th_low));
    assign deficit = CW'(th_low) - CW'(opto_code);
    assign p_add   = tick_t'(deficit) * stretch_step;
    assign p_str   = pmax + p_add;

    region_e reg_sel;
    tick_t   t_ref;
    tick_t   p_sel;

    always_comb begin
        if (in_full) begin
            reg_sel = REG_FULL;
            t_ref   = t_full;
            p_sel   = pmax;
        end else if (!in_low) begin
            reg_sel = REG_TRIM;
            t_ref   = t_trim;
            p_sel   = pmax;
        end else begin
            reg_sel = REG_STRETCH;
            t_ref   = tick_t'(TON_MIN);
            p_sel   = p_str;
        end
    end

    // soft-start gain, saturating at unity (65536)
    logic [31:0]    ss_prod;
    logic [16:0]    ss_gain;
    logic [SSW-1:0] t_ss_w;
    logic [SSW-1:0] t_ss_sh;
    tick_t          hp;

    assign ss_prod = 32'(ss_level) * 32'(SS_NUM);
    assign ss_gain = (ss_prod > 32'd65536) ? 17'h10000 : ss_prod[16:0];
    assign t_ss_w  = SSW'(t_ref) * SSW'(ss_gain);
    assign t_ss_sh = t_ss_w >> 16;
    assign hp      = high_phase(p_sel);

    always_comb begin
        plan.period = p_sel;
        plan.high   = hp;
        plan.ontime = (t_ss_sh > SSW'(hp)) ? hp : t_ss_sh[TW-1:0];
        plan.region = reg_sel;
    end

endmodule

// File: rtl/ffpwm_cycle_timer.sv
module ffpwm_cycle_timer
    import ffpwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cycle_plan_t plan_next,
    output logic        cyc_start,
    output logic        cyc_clk,
    output tick_t       on_time,
    output region_e     region
);

    tick_t       cnt_q;
    cycle_plan_t plan_q;
    logic        primed_q;
    logic        strobe_q;
    logic        clk_q;
    logic        next_start;
    tick_t       cnt_inc;

    assign cnt_inc    = cnt_q + tick_t'(1);
    assign next_start = !primed_q || (cnt_inc == plan_q.period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            plan_q   <= '0;
            primed_q <= 1'b0;
            strobe_q <= 1'b0;
            clk_q    <= 1'b0;
        end else if (next_start) begin
            cnt_q    <= '0;
            plan_q   <= plan_next;
            primed_q <= 1'b1;
            strobe_q <= 1'b1;
            clk_q    <= (plan_next.high != '0);
        end else begin
            cnt_q    <= cnt_inc;
            strobe_q <= 1'b0;
            clk_q    <= (cnt_inc < plan_q.high);
        end
    end

    assign cyc_start = strobe_q;
    assign cyc_clk   = clk_q;
    assign on_time   = plan_q.ontime;
    assign region    = plan_q.region;

endmodule

// File: rtl/ffpwm_gen.sv
module ffpwm_gen
    import ffpwm_pkg::*;
#(
    parameter int VIN_W    = 8,
    parameter int OPTO_W   = 8,
    parameter int IREF_W   = 4,
    parameter int SS_W     = 8,
    parameter int PERIOD_K = 700,
    parameter int VD_K     = 64,
    parameter int DMAX_SH  = 7,
    parameter int TON_MIN  = 6,
    parameter int SS_NUM   = 301,
    localparam int TH_W    = IREF_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VIN_W-1:0]  vin_code,
    input  logic [OPTO_W-1:0] opto_code,
    input  logic [IREF_W-1:0] iref_sel,
    input  logic [SS_W-1:0]   ss_level,
    output logic              cyc_start,
    output logic              cyc_clk,
    output logic [15:0]       on_time,
    output logic [1:0]        region
);

    tick_t           pmax;
    tick_t           stretch_step;
    logic [TH_W-1:0] th_low;
    cycle_plan_t     plan_next;
    tick_t           on_time_t;
    region_e         region_t;

    ffpwm_ref_lut #(
        .IREF_W  (IREF_W),
        .PERIOD_K(PERIOD_K)
    ) u_ref (
        .iref_sel    (iref_sel),
        .pmax        (pmax),
        .stretch_step(stretch_step),
        .th_low      (th_low)
    );

    ffpwm_ontime_calc #(
        .IREF_W (IREF_W),
        .VIN_W  (VIN_W),
        .OPTO_W (OPTO_W),
        .SS_W   (SS_W),
        .VD_K   (VD_K),
        .DMAX_SH(DMAX_SH),
        .TON_MIN(TON_MIN),
        .SS_NUM (SS_NUM)
    ) u_calc (
        .vin_code    (vin_code),
        .opto_code   (opto_code),
        .ss_level    (ss_level),
        .pmax        (pmax),
        .stretch_step(stretch_step),
        .th_low      (th_low),
        .plan        (plan_next)
    );

    ffpwm_cycle_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .plan_next(plan_next),
        .cyc_start(cyc_start),
        .cyc_clk  (cyc_clk),
        .on_time  (on_time_t),
        .region   (region_t)
    );

    assign on_time = on_time_t;
    assign region  = region_t;

endmodule

// File: rtl/ffpwm_chk.sv
module ffpwm_chk #(
    parameter int PERIOD_K = 700
) (
    input logic        clk,
    input logic        rst,
    input logic        cyc_start,
    input logic        cyc_clk,
    input logic [15:0] on_time,
    input logic [1:0]  region
);

    logic [16:0] since_q;
    logic [15:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            hi_q    <= '0;
        end else begin
            if (cyc_start)                since_q <= 17'd1;
            else if (since_q != '1)       since_q <= since_q + 17'd1;
            if (cyc_start)                hi_q <= 16'd1;
            else if (cyc_clk)             hi_q <= hi_q + 16'd1;
        end
    end

    // R1: reset clears every output
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!cyc_start && !cyc_clk && on_time == 16'd0 && region == 2'd0));

    // R10: start strobe comes with the clock high
    assert_start_high_R10: assert property (@(posedge clk) disable iff (rst)
        cyc_start |-> cyc_clk);

    // R10: the phase clock rises only at a cycle start
    assert_rise_at_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_clk) |-> cyc_start);

    // R9: latched values hold between starts
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |-> ($stable(on_time) && $stable(region)));

    // R3: on-time fits inside the high phase just ended
    assert_ontime_fits_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cyc_clk) |-> (on_time <= hi_q));

    // R11: no cycle longer than five times the top-frequency bound
    assert_period_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && since_q != 17'd0) |-> (since_q <= 17'(5 * PERIOD_K)));

    // R5-R7: region code is one of the three defined values
    assert_region_code_R5: assert property (@(posedge clk) disable iff (rst)
        region != 2'd3);

endmodule

bind ffpwm_gen ffpwm_chk #(.PERIOD_K(PERIOD_K)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cyc_start(cyc_start),
    .cyc_clk  (cyc_clk),
    .on_time  (on_time),
    .region   (region)
);

// File: tb/ffpwm_gen_tb.sv
module ffpwm_gen_tb;

    localparam int PK   = 700;
    localparam int VDK  = 64;
    localparam int DSH  = 7;
    localparam int TMIN = 6;
    localparam int SSN  = 301;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  vin_code  = 8'd128;
    logic [7:0]  opto_code = 8'd255;
    logic [3:0]  iref_sel  = 4'd15;
    logic [7:0]  ss_level  = 8'd255;
    logic        cyc_start;
    logic        cyc_clk;
    logic [15:0] on_time;
    logic [1:0]  region;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    ffpwm_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .vin_code (vin_code),
        .opto_code(opto_code),
        .iref_sel (iref_sel),
        .ss_level (ss_level),
        .cyc_start(cyc_start),
        .cyc_clk  (cyc_clk),
        .on_time  (on_time),
        .region   (region)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // expected cycle plan, from the requirement formulas
    task automatic model(input int ir, input int vin, input int op, input int ss,
                         output int p, output int h, output int t, output int rg);
        longint ie, pm, hm, v, rc, ff, tf, th, tr, sg, ts;
        ie = (ir == 0) ? 1 : ir;
        pm = PK / ie;
        hm = (pm * 7) / 10;
        v  = (vin == 0) ? 1 : vin;
        rc = 65536 / v;
        ff = (pm * VDK * rc) >> 16;
        tf = (ff < hm) ? ff : hm;
        th = 4 * ie;
        if (op >= (1 << DSH)) begin
            rg = 0; tr = tf; p = int'(pm);
        end else if (op >= th) begin
            rg = 1; tr = (tf * op) >> DSH;
            if (tr < TMIN) tr = TMIN;
            p = int'(pm);
        end else begin
            rg = 2; tr = TMIN;
            p = int'(pm + (th - op) * (PK / (ie * ie)));
        end
        sg = longint'(ss) * SSN;
        if (sg > 65536) sg = 65536;
        ts = (tr * sg) >> 16;
        h  = (p * 7) / 10;
        t  = (ts < h) ? int'(ts) : h;
    endtask

    task automatic run_case(input int ir, input int vin, input int op, input int ss,
                            input string tag, output int per_o);
        int p, h, t, rg, per, hi, t0;
        bit stable;
        iref_sel  = 4'(ir);
        vin_code  = 8'(vin);
        opto_code = 8'(op);
        ss_level  = 8'(ss);
        model(ir, vin, op, ss, p, h, t, rg);
        @(posedge clk);
        do @(negedge clk); while (!cyc_start);
        check(cyc_clk == 1'b1, "R10 clock high at start", cyc_clk, 1);
        check(on_time == 16'(t), tag, on_time, t);
        check(region == 2'(rg), "R5 region code", region, rg);
        t0 = on_time; per = 0; hi = 0; stable = 1'b1;
        do begin
            per++;
            if (cyc_clk) hi++;
            if (on_time != 16'(t0)) stable = 1'b0;
            @(negedge clk);
        end while (!cyc_start);
        check(per == p, (rg == 2) ? "R7 stretched period" : "R2 period", per, p);
        check(hi == h, "R3 high phase", hi, h);
        check(stable, "R9 on_time stable in cycle", stable, 1);
        per_o = per;
    endtask

    initial begin
        int per;
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!cyc_start && !cyc_clk && on_time == 0 && region == 0,
              "R1 reset outputs", {cyc_start, cyc_clk, on_time, region}, 0);
        rst = 1'b0;

        // R2/R4: reference sweep at full power
        for (int ir = 0; ir < 16; ir++)
            run_case(ir, 128, 255, 255, "R4 ontime vs reference", per);

        // R4: input-voltage sweep, feed-forward
        for (int v = 0; v < 256; v++)
            run_case(15, v, 200, 255, "R4 feed-forward ontime", per);

        // R5/R6/R7: opto sweep across the three regions
        for (int op = 0; op < 256; op++)
            run_case(12, 90, op, 255,
                     (op >= 128) ? "R5 full ontime" : (op >= 48) ? "R6 trim ontime" : "R7 min ontime",
                     per);

        // R8: soft-start sweep
        for (int s = 0; s < 256; s++)
            run_case(15, 80, 255, s, "R8 soft-start ontime", per);
        run_case(15, 80, 100, 120, "R8 soft-start in trim", per);
        run_case(15, 80, 10, 30, "R8 soft-start in stretch", per);

        // R11: lowest opto code bounds the period
        for (int ir = 4; ir < 16; ir++) begin
            run_case(ir, 128, 0, 255, "R7 min ontime at zero opto", per);
            check(per * ir <= 5 * PK, "R11 period bound", per * ir, 5 * PK);
        end

        // R9: mid-cycle input change takes effect only at the next start
        begin
            int pa, ha, ta, ra, pb, hb, tb, rb;
            bit held;
            run_case(15, 100, 255, 255, "R9 baseline ontime", per);
            model(15, 100, 255, 255, pa, ha, ta, ra);
            model(15, 200, 255, 255, pb, hb, tb, rb);
            repeat (5) @(negedge clk);
            vin_code = 8'd200;
            held = 1'b1;
            while (!cyc_start) begin
                if (on_time != 16'(ta)) held = 1'b0;
                @(negedge clk);
            end
            check(held, "R9 ontime held after mid-cycle change", held, 1);
            check(on_time == 16'(tb), "R9 new ontime at next start", on_time, tb);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule